// File: doc/BRIEF.md
# I2C Bit-Rate Divider with Quarter-Bit Phase Strobes

This block turns a fast system clock into the timing grid of an I2C bus master. A 7-bit rate word packs a linear factor `m` and a power-of-two exponent `n`. The divider runs three cascaded stages: a 2^n prescaler, an (m+1) counter and a ten-position stage. Together they give one bit period of 10·(m+1)·2^n system clocks.

The ten-position stage also places four one-cycle phase strobes inside each bit period. The byte engine uses them to raise and lower SCL and to sample SDA. A rate word written while the divider runs is held as pending and takes effect only at the next bit boundary, so SCL never gets a shortened period. When `run_en` is low, all counters sit at zero and no strobes come out.

Top module: `i2c_rate_divider`

## Requirements
- R1: The rate word carries `m` in bits 6:3 (0 to 15) and `n` in bits 2:0 (0 to 7).
- R2: While running with an unchanged setting, `bit_tick` pulses once every 10·(m+1)·2^n system clocks.
- R3: After a synchronous reset the setting is 0x44 (m=8, n=4), giving a 1440-clock period. Any loaded word is discarded, and the outputs are low while `rst` is high.
- R4: At most one bit of `phase_stb` is high in any cycle. `phase_stb[0]` pulses together with `bit_tick`. `phase_stb[1]`, `phase_stb[2]` and `phase_stb[3]` pulse 3, 5 and 8 units after it, where one unit is (m+1)·2^n clocks.
- R5: A word loaded while running does not change the period in progress. The period after the next `bit_tick` uses the new word.
- R6: A word loaded while `run_en` is low is used from the first period after `run_en` rises.
- R7: From the cycle after `run_en` is sampled low, no strobe or tick is produced. On restart, the first `bit_tick` is high in the cycle after the P-th rising edge that samples `run_en` high, where P is the period.
- R8: The extreme settings give periods of 10 clocks (m=0, n=0) and 20480 clocks (m=15, n=7).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Enables counting; low holds all stages at zero |
| cfg_word | input | 7 | Rate word: m in 6:3, n in 2:0 |
| cfg_load | input | 1 | One-cycle strobe that captures `cfg_word` as pending |
| phase_stb | output | 4 | Quarter-bit phase strobes, one-cycle pulses |
| bit_tick | output | 1 | One-cycle pulse at each bit-period boundary |

## Verification
The period is measured for several (m, n) pairs:
- Pairs where only the exponent is non-zero and pairs where only the linear factor is non-zero expose any mix-up between the two stages.
- An asymmetric pair (m=2, n=5) reveals swapped field positions.
- The two extremes cover the shortest and longest chains.

A rate word loaded in the middle of a running period shows whether the change waits for the boundary. A reset after a load shows that the setting returns to its default. The phase offsets are compared with the unit length in every measured period, and a timed restart pins down the first-tick latency.

// File: rtl/i2c_rate_pkg.sv
package i2c_rate_pkg;

    localparam int M_W    = 4;
    localparam int N_W    = 3;
    localparam int CFG_W  = M_W + N_W;
    localparam int PRE_W  = (1 << N_W) - 1;
    localparam int NUM_PH = 4;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
    } rate_cfg_t;

    // Position in the span at which quarter k begins (rounded to nearest).
    function automatic int phase_pos(input int k, input int span);
        return (k * span + NUM_PH / 2) / NUM_PH;
    endfunction

endpackage

// File: rtl/rate_setting.sv
module rate_setting
    import i2c_rate_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_CFG = 7'h44
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             cfg_load,
    input  logic             boundary,
    output rate_cfg_t        act_o
);

    rate_cfg_t pend;
    logic      pend_vld;
    logic      apply;

    assign apply = pend_vld && (!run_en || boundary);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_o    <= rate_cfg_t'(RESET_CFG);
            pend     <= rate_cfg_t'(RESET_CFG);
            pend_vld <= 1'b0;
        end else begin
            if (apply) begin
                act_o <= pend;
            end
            if (cfg_load) begin
                pend     <= rate_cfg_t'(cfg_word);
                pend_vld <= 1'b1;
            end else if (apply) begin
                pend_vld <= 1'b0;
            end
        end
    end

    // R5: the active setting never moves inside a running period
    p_hold_midperiod_r5: assert property (@(posedge clk) disable iff (rst)
        (run_en && !boundary) |=> $stable(act_o));

endmodule

// File: rtl/rate_pow2_stage.sv
module rate_pow2_stage
    import i2c_rate_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           run_en,
    input  logic [N_W-1:0] exp_n,
    output logic           tick_o
);

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] lim;

    assign lim    = ~({PRE_W{1'b1}} << exp_n);
    assign tick_o = run_en && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            cnt <= '0;
        end else if (tick_o) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: prescaler never passes its terminal count
    p_pre_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= lim);

endmodule

// File: rtl/rate_linear_stage.sv
module rate_linear_stage
    import i2c_rate_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           run_en,
    input  logic           in_tick,
    input  logic [M_W-1:0] lin_m,
    output logic           tick_o
);

    logic [M_W-1:0] cnt;

    assign tick_o = in_tick && (cnt == lin_m);

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            cnt <= '0;
        end else if (tick_o) begin
            cnt <= '0;
        end else if (in_tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: linear counter stays within m
    p_lin_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= lin_m);

endmodule

// File: rtl/rate_phase_stage.sv
module rate_phase_stage
    import i2c_rate_pkg::*;
#(
    parameter int SPAN = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              step,
    output logic              wrap_o,
    output logic [NUM_PH-1:0] phase_o,
    output logic              bit_tick_o
);

    localparam int            DW   = $clog2(SPAN);
    localparam logic [DW-1:0] LAST = DW'(SPAN - 1);

    logic [DW-1:0]     pos;
    logic [DW-1:0]     nxt;
    logic [NUM_PH-1:0] hit;

    assign nxt    = (pos == LAST) ? '0 : pos + 1'b1;
    assign wrap_o = step && (pos == LAST);

    for (genvar k = 0; k < NUM_PH; k++) begin : g_phase
        localparam logic [DW-1:0] AT = DW'(phase_pos(k, SPAN));
        assign hit[k] = step && (nxt == AT);
    end

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            pos        <= '0;
            phase_o    <= '0;
            bit_tick_o <= 1'b0;
        end else begin
            if (step) begin
                pos <= nxt;
            end
            phase_o    <= hit;
            bit_tick_o <= wrap_o;
        end
    end

    // R4: phase strobes never overlap
    p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phase_o));

    // R7: stopped divider stays silent
    p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (phase_o == '0 && !bit_tick_o));

    // R2: a period is never a single clock
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        bit_tick_o |=> !bit_tick_o);

endmodule

// File: rtl/i2c_rate_divider.sv
module i2c_rate_divider
    import i2c_rate_pkg::*;
#(
    parameter int               SPAN      = 10,
    parameter logic [CFG_W-1:0] RESET_CFG = 7'h44
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              cfg_load,
    output logic [NUM_PH-1:0] phase_stb,
    output logic              bit_tick
);

    rate_cfg_t act;
    logic      pre_tick;
    logic      mid_tick;
    logic      wrap;

    rate_setting #(.RESET_CFG(RESET_CFG)) u_setting (
        .clk      (clk),
        .rst      (rst),
        .run_en   (run_en),
        .cfg_word (cfg_word),
        .cfg_load (cfg_load),
        .boundary (wrap),
        .act_o    (act)
    );

    rate_pow2_stage u_pow2 (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .exp_n  (act.n),
        .tick_o (pre_tick)
    );

    rate_linear_stage u_linear (
        .clk     (clk),
        .rst     (rst),
        .run_en  (run_en),
        .in_tick (pre_tick),
        .lin_m   (act.m),
        .tick_o  (mid_tick)
    );

    rate_phase_stage #(.SPAN(SPAN)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .step       (mid_tick),
        .wrap_o     (wrap),
        .phase_o    (phase_stb),
        .bit_tick_o (bit_tick)
    );

endmodule

// File: tb/i2c_rate_divider_tb.sv
module i2c_rate_divider_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    typedef struct {
        int    period;
        string tag;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst;
    logic       run_en;
    logic [6:0] cfg_word;
    logic       cfg_load;
    logic [3:0] phase_stb;
    logic       bit_tick;

    int checks   = 0;
    int failures = 0;

    exp_item_t exp_q[$];
    int        cyc       = 0;
    int        last_tick = 0;
    bit        have_last = 1'b0;
    int        off[4];

    i2c_rate_divider u_dut (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .cfg_word  (cfg_word),
        .cfg_load  (cfg_load),
        .phase_stb (phase_stb),
        .bit_tick  (bit_tick)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int period_of(input int m, input int n);
        return 10 * (m + 1) * (1 << n);
    endfunction

    // Monitor: measures tick intervals and phase offsets, compares with queue
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            for (int k = 1; k < 4; k++) begin
                if (phase_stb[k]) off[k] = cyc - last_tick;
            end
            if (bit_tick) begin
                if (have_last && exp_q.size() > 0) begin
                    automatic exp_item_t e = exp_q.pop_front();
                    automatic int unit = e.period / 10;
                    automatic int pos[4] = '{0, 3, 5, 8};
                    check(cyc - last_tick == e.period, e.tag, cyc - last_tick, e.period);
                    for (int k = 1; k < 4; k++) begin
                        check(off[k] == pos[k] * unit, "R4 phase offset", off[k], pos[k] * unit);
                    end
                    check(phase_stb == 4'b0001, "R4 phase0 with tick", int'(phase_stb), 1);
                end
                last_tick = cyc;
                have_last = 1'b1;
                for (int k = 0; k < 4; k++) off[k] = -1;
            end
        end
    end

    task automatic stop_run();
        @(posedge clk); #1;
        run_en    = 1'b0;
        have_last = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic load_word(input int m, input int n);
        @(posedge clk); #1;
        cfg_word = {4'(m), 3'(n)};
        cfg_load = 1'b1;
        @(posedge clk); #1;
        cfg_load = 1'b0;
    endtask

    task automatic push_n(input int p, input int count, input string tag);
        for (int i = 0; i < count; i++) exp_q.push_back('{p, tag});
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        #1;
    endtask

    // Load while idle (R6), then measure a number of periods
    task automatic run_cfg(input int m, input int n, input int count, input string tag);
        stop_run();
        load_word(m, n);
        repeat (2) @(posedge clk);
        #1;
        push_n(period_of(m, n), count, tag);
        run_en = 1'b1;
        drain();
        stop_run();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, -1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        run_en   = 1'b0;
        cfg_word = '0;
        cfg_load = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check(phase_stb == 4'b0 && bit_tick == 1'b0, "R3 outputs in reset",
              int'({phase_stb, bit_tick}), 0);
        @(posedge clk); #1;
        rst = 1'b0;

        // R3: default setting gives 1440 clocks
        push_n(1440, 2, "R3 default period");
        run_en = 1'b1;
        drain();
        stop_run();

        // R8 minimum, R6 idle load
        run_cfg(0, 0, 3, "R8 min period");
        // R1 field layout: asymmetric pair, then single-field pairs
        run_cfg(2, 5, 2, "R1 m=2 n=5");
        run_cfg(5, 0, 2, "R2 m only");
        run_cfg(0, 3, 2, "R6 n only idle load");

        // R5: load while running, mid-period
        load_word(8, 0);
        repeat (2) @(posedge clk);
        #1;
        push_n(90, 2, "R5 old period");
        run_en = 1'b1;
        while (exp_q.size() != 1) @(posedge clk);
        repeat (20) @(posedge clk);
        #1;
        cfg_word = {4'd1, 3'd1};
        cfg_load = 1'b1;
        @(posedge clk); #1;
        cfg_load = 1'b0;
        push_n(40, 2, "R5 new period");
        drain();
        stop_run();

        // R7: restart latency with P=40
        load_word(0, 2);
        repeat (2) @(posedge clk);
        #1;
        run_en = 1'b1;
        begin
            automatic int edges = 0;
            while (edges < 1000) begin
                @(posedge clk);
                edges++;
                @(negedge clk);
                if (bit_tick) break;
            end
            #1;
            check(edges == 40, "R7 first tick latency", edges, 40);
        end
        // R7: silence while stopped
        stop_run();
        begin
            automatic int seen = 0;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (bit_tick || phase_stb != 4'b0) seen++;
            end
            #1;
            check(seen == 0, "R7 quiet when stopped", seen, 0);
        end

        // R8 maximum
        run_cfg(15, 7, 2, "R8 max period");

        // R3: reset after a load returns to default
        load_word(3, 3);
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        push_n(1440, 2, "R3 default after reset");
        run_en = 1'b1;
        drain();
        stop_run();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule